// File: doc/BRIEF.md
# DDR SDRAM Command and Bank Tracker

This block watches the command pins of a four-bank DDR SDRAM rank from the controller side. On every rising clock edge it samples chip select, the three active-low strobes (RAS#, CAS#, WE#), the bank address, the twelve address lines and the clock enable. It turns them into one command and keeps a model of the rank: which banks hold an open row, and which row each one holds.

Read and write bursts are tracked. Each burst lasts half as many clocks as its programmed length, because two data beats move per clock. The programmed length is 2, 4 or 8. Address bit 10 has two meanings. On a read or write it asks for the bank to close by itself when the burst ends. On a precharge it widens the close from the addressed bank to every bank.

A single-cycle error pulse flags protocol misuse. Examples are a read or write to a closed bank, a second activate to an open bank, a refresh or mode write while any row is open, and clock enable dropping inside a burst. When clock enable is sampled low, the block reports which power-down state the rank enters. Precharge power-down applies when all banks are idle and active power-down when any row is open.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: After reset, all banks are closed, every row register reads zero, the error pulse and the burst flag are low, the burst length reads 2 and the power-down report reads 0.
- R2: With chip select sampled high, the command is treated as no operation and no bank state changes. The command code is taken as {RAS#, CAS#, WE#}: 000 mode write, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 111 no operation.
- R3: An activate to a closed bank opens it and stores A11..A0 as its row. An activate to an open bank pulses the error output and leaves that bank's row unchanged.
- R4: A precharge with A10 low closes only the addressed bank. A precharge with A10 high closes all banks.
- R5: A read or write to a closed bank pulses the error output and starts no burst.
- R6: An accepted read or write raises the burst flag for BL/2 clock cycles after the command edge.
- R7: A read or write with A10 high closes its bank on the same edge where the burst flag falls. Without A10 the bank stays open.
- R8: A mode write sets the burst length from A2..A0, where 1 selects 2, 2 selects 4 and 3 selects 8. Any other code pulses the error output and keeps the old length. A mode write or a refresh while any bank is open pulses the error output and changes nothing.
- R9: Clock enable sampled low while the burst flag is high pulses the error output.
- R10: Clock enable sampled low sets the power-down report to 1 if all banks were idle and to 2 if any row was open, and any command sampled in that cycle is ignored. Clock enable high sets the report to 0.
- R11: A read or write issued while a burst with auto close is running pulses the error output and is ignored. A precharge covering that burst's bank cancels the pending auto close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row, column, auto-close/all-banks flag (bit 10), or mode code (bits 2..0) |
| cke | input | 1 | Clock enable |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| bank_row | output | 48 | Open row of each bank, bank n at bits 12n+11..12n |
| burst_busy | output | 1 | High while a burst occupies the data bus |
| burst_len | output | 4 | Programmed burst length (2, 4 or 8) |
| proto_err | output | 1 | One-cycle pulse on a protocol violation |
| pd_mode | output | 2 | Power-down report: 0 none, 1 precharge, 2 active |

## Verification
The costly coincidence is the last clock of an auto-closing burst landing on the same edge as a new command to that bank. The bench arms a write with auto close, waits until one burst clock remains, and then issues an activate to the same bank. At that edge the bank is still open, so an error is expected and the bank must end up closed. An activate one edge later must then be accepted without error. The same count is reused to drop clock enable exactly on the final burst clock: an error and the active power-down report are expected together. A precharge in the middle of an auto-close burst, followed by a fresh activate, shows that the cancelled auto close does not close the new row.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

   typedef enum logic [2:0] {
      CMD_MRS = 3'b000,
      CMD_REF = 3'b001,
      CMD_PRE = 3'b010,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_RD  = 3'b101,
      CMD_RSV = 3'b110,
      CMD_NOP = 3'b111
   } cmd_e;

   typedef enum logic [1:0] {
      PD_NONE   = 2'd0,
      PD_PRECHG = 2'd1,
      PD_ACTIVE = 2'd2
   } pd_e;

   // burst length code is log2 of the length
   localparam logic [1:0] BLC_RESET = 2'd1;

   function automatic logic bl_code_legal(input logic [2:0] code);
      return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
   endfunction

endpackage

// File: rtl/ddr_trk_decode.sv
module ddr_trk_decode
   import ddr_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic cke,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n || !cke) cmd = CMD_NOP;
      else              cmd = cmd_e'({ras_n, cas_n, we_n});
   end

endmodule

// File: rtl/ddr_trk_bank.sv
module ddr_trk_bank #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_i,
   input  logic             close_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             is_open,
   output logic [ROW_W-1:0] row_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_o   <= '0;
      end else if (close_i) begin
         is_open <= 1'b0;
      end else if (open_i) begin
         is_open <= 1'b1;
         row_o   <= row_i;
      end
   end

endmodule

// File: rtl/ddr_trk_burst.sv
module ddr_trk_burst #(
   parameter int BA_W     = 2,
   parameter int MAX_HALF = 4,
   localparam int CNT_W   = $clog2(MAX_HALF + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_ap,
   input  logic [BA_W-1:0]  start_bank,
   input  logic [CNT_W-1:0] half_len,
   input  logic             cancel_ap,
   output logic             busy,
   output logic             ap_pend,
   output logic             ap_done,
   output logic [BA_W-1:0]  cur_bank
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         ap_pend  <= 1'b0;
         cur_bank <= '0;
      end else if (start) begin
         cnt      <= half_len;
         ap_pend  <= start_ap;
         cur_bank <= start_bank;
      end else begin
         if (cnt != '0) cnt <= cnt - 1'b1;
         if (cancel_ap || cnt == CNT_W'(1)) ap_pend <= 1'b0;
      end
   end

   assign busy    = (cnt != '0);
   assign ap_done = ap_pend && (cnt == CNT_W'(1));

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
   import ddr_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int AP_BIT    = 10,
   parameter int MAX_BL    = 8,
   localparam int BA_W     = $clog2(NUM_BANKS),
   localparam int MAX_HALF = MAX_BL / 2,
   localparam int CNT_W    = $clog2(MAX_HALF + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BA_W-1:0]            ba,
   input  logic [ROW_W-1:0]           addr,
   input  logic                       cke,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_row,
   output logic                       burst_busy,
   output logic [3:0]                 burst_len,
   output logic                       proto_err,
   output logic [1:0]                 pd_mode
);

   // elaboration-time parameter checks
   if (NUM_BANKS != (1 << BA_W)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two");
   end
   if (AP_BIT >= ROW_W || AP_BIT < 3) begin : g_bad_ap
      $error("AP_BIT must lie inside the address and above the mode code");
   end
   if (MAX_BL != 8) begin : g_bad_bl
      $error("MAX_BL must be 8 for the supported burst codes");
   end

   cmd_e                 cmd;
   logic [1:0]           bl_code;
   logic [CNT_W-1:0]     half_len;
   logic                 any_open, sel_open;
   logic                 b_busy, b_ap_pend, b_ap_done;
   logic [BA_W-1:0]      b_bank;
   logic                 rw_start, act_ok, cancel_ap;
   logic [NUM_BANKS-1:0] open_vec, close_vec, pre_mask;
   logic                 err_next;
   logic                 mrs_ok;

   ddr_trk_decode u_dec (
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cke  (cke),
      .cmd  (cmd)
   );

   assign any_open = |bank_open;
   assign sel_open = bank_open[ba];
   assign half_len = CNT_W'((4'd1 << bl_code) >> 1);

   always_comb begin
      act_ok    = 1'b0;
      rw_start  = 1'b0;
      pre_mask  = '0;
      mrs_ok    = 1'b0;
      err_next  = 1'b0;
      case (cmd)
         CMD_ACT: begin
            if (sel_open) err_next = 1'b1;
            else          act_ok   = 1'b1;
         end
         CMD_RD, CMD_WR: begin
            if (!sel_open || b_ap_pend) err_next = 1'b1;
            else                        rw_start = 1'b1;
         end
         CMD_PRE: begin
            if (addr[AP_BIT]) pre_mask = '1;
            else              pre_mask[ba] = 1'b1;
         end
         CMD_REF: begin
            if (any_open) err_next = 1'b1;
         end
         CMD_MRS: begin
            if (any_open || !bl_code_legal(addr[2:0])) err_next = 1'b1;
            else                                       mrs_ok   = 1'b1;
         end
         default: ;
      endcase
      if (!cke && b_busy) err_next = 1'b1;
      cancel_ap = pre_mask[b_bank];
   end

   for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign open_vec[gb]  = act_ok && (ba == BA_W'(gb));
      assign close_vec[gb] = pre_mask[gb] || (b_ap_done && (b_bank == BA_W'(gb)));

      ddr_trk_bank #(.ROW_W(ROW_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .open_i (open_vec[gb]),
         .close_i(close_vec[gb]),
         .row_i  (addr),
         .is_open(bank_open[gb]),
         .row_o  (bank_row[gb*ROW_W +: ROW_W])
      );
   end

   ddr_trk_burst #(.BA_W(BA_W), .MAX_HALF(MAX_HALF)) u_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rw_start),
      .start_ap  (addr[AP_BIT]),
      .start_bank(ba),
      .half_len  (half_len),
      .cancel_ap (cancel_ap),
      .busy      (b_busy),
      .ap_pend   (b_ap_pend),
      .ap_done   (b_ap_done),
      .cur_bank  (b_bank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bl_code   <= BLC_RESET;
         proto_err <= 1'b0;
         pd_mode   <= PD_NONE;
      end else begin
         if (mrs_ok) bl_code <= addr[1:0];
         proto_err <= err_next;
         if (cke)           pd_mode <= PD_NONE;
         else if (any_open) pd_mode <= PD_ACTIVE;
         else               pd_mode <= PD_PRECHG;
      end
   end

   assign burst_busy = b_busy;
   assign burst_len  = 4'd1 << bl_code;

endmodule

// File: rtl/ddr_trk_chk.sv
module ddr_trk_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cs_n,
   input logic                       ras_n,
   input logic                       cas_n,
   input logic                       we_n,
   input logic [BA_W-1:0]            ba,
   input logic [ROW_W-1:0]           addr,
   input logic                       cke,
   input logic [NUM_BANKS-1:0]       bank_open,
   input logic                       burst_busy,
   input logic [3:0]                 burst_len,
   input logic                       proto_err,
   input logic [1:0]                 pd_mode
);

   logic live;
   logic [2:0] code;
   assign live = !cs_n && cke;
   assign code = {ras_n, cas_n, we_n};

   AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n && !burst_busy |=> $stable(bank_open)) else $error("masked command changed banks"); // R2

   AST_ACT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
      live && code == 3'b011 && bank_open[ba] |=> proto_err) else $error("activate to open bank not flagged"); // R3

   AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      live && code == 3'b010 && addr[AP_BIT] |=> bank_open == '0) else $error("precharge all left a bank open"); // R4

   AST_RW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      live && (code == 3'b101 || code == 3'b100) && !bank_open[ba] |=> proto_err) else $error("access to closed bank not flagged"); // R5

   AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      live && code == 3'b000 && (|bank_open) |=> $stable(burst_len) && proto_err) else $error("mode write with open bank accepted"); // R8

   AST_CKE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      !cke && burst_busy |=> proto_err) else $error("clock enable drop in burst not flagged"); // R9

   AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cke && bank_open == '0 |=> pd_mode == 2'd1) else $error("idle power-down misreported"); // R10

endmodule

bind ddr_cmd_tracker ddr_trk_chk #(
   .NUM_BANKS(NUM_BANKS),
   .ROW_W    (ROW_W),
   .AP_BIT   (AP_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .cke       (cke),
   .bank_open (bank_open),
   .burst_busy(burst_busy),
   .burst_len (burst_len),
   .proto_err (proto_err),
   .pd_mode   (pd_mode)
);

// File: tb/tb_ddr_cmd_tracker.sv
`timescale 1ns/1ps
module tb_ddr_cmd_tracker;

   localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                          C_ACT = 3'b011, C_WR  = 3'b100, C_RD  = 3'b101,
                          C_NOP = 3'b111;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic        cke = 1'b1;
   logic [3:0]  bank_open;
   logic [47:0] bank_row;
   logic        burst_busy;
   logic [3:0]  burst_len;
   logic        proto_err;
   logic [1:0]  pd_mode;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   ddr_cmd_tracker dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .cke(cke),
      .bank_open(bank_open), .bank_row(bank_row), .burst_busy(burst_busy),
      .burst_len(burst_len), .proto_err(proto_err), .pd_mode(pd_mode)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [11:0] a,
                        input logic cs = 1'b0, input logic ck = 1'b1);
      cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a; cke = ck;
      @(posedge clk); @(negedge clk);
      cs_n = 1'b0; {ras_n, cas_n, we_n} = C_NOP; addr = '0; cke = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R1 banks", bank_open, 0);
      chk("R1 rows", bank_row, 0);
      chk("R1 err", proto_err, 0);
      chk("R1 busy", burst_busy, 0);
      chk("R1 len", burst_len, 2);
      chk("R1 pd", pd_mode, 0);
   endtask

   task automatic t_mask;
      issue(C_ACT, 2'd0, 12'h055, 1'b1);
      chk("R2 masked act", bank_open, 0);
      chk("R2 no err", proto_err, 0);
   endtask

   task automatic t_activate;
      issue(C_ACT, 2'd2, 12'hABC);
      chk("R3 open", bank_open, 4'b0100);
      chk("R3 row", bank_row[35:24], 12'hABC);
      chk("R3 err clear", proto_err, 0);
      issue(C_ACT, 2'd2, 12'h123);
      chk("R3 double act err", proto_err, 1);
      chk("R3 row kept", bank_row[35:24], 12'hABC);
   endtask

   task automatic t_closed_rw;
      issue(C_RD, 2'd0, 12'h010);
      chk("R5 read closed err", proto_err, 1);
      chk("R5 no burst", burst_busy, 0);
      issue(C_WR, 2'd3, 12'h000);
      chk("R5 write closed err", proto_err, 1);
   endtask

   task automatic t_mode;
      issue(C_MRS, 2'd0, 12'h003);
      chk("R8 mrs open err", proto_err, 1);
      chk("R8 len kept", burst_len, 2);
      issue(C_PRE, 2'd2, 12'h000);
      chk("R4 single close", bank_open, 0);
      issue(C_MRS, 2'd0, 12'h003);
      chk("R8 mrs ok", proto_err, 0);
      chk("R8 len 8", burst_len, 8);
      issue(C_MRS, 2'd0, 12'h006);
      chk("R8 bad code err", proto_err, 1);
      chk("R8 bad code len", burst_len, 8);
      issue(C_REF, 2'd0, 12'h000);
      chk("R8 ref idle ok", proto_err, 0);
      issue(C_ACT, 2'd0, 12'h001);
      issue(C_REF, 2'd0, 12'h000);
      chk("R8 ref open err", proto_err, 1);
      issue(C_PRE, 2'd0, 12'h400);
   endtask

   task automatic t_burst8;
      issue(C_ACT, 2'd1, 12'h005);
      issue(C_RD, 2'd1, 12'h000);
      chk("R6 busy start", burst_busy, 1);
      for (int i = 0; i < 3; i++) begin
         idle(1);
         chk("R6 busy hold", burst_busy, 1);
      end
      idle(1);
      chk("R6 busy end", burst_busy, 0);
      chk("R7 no ap stays open", bank_open, 4'b0010);
      // auto close cancelled by precharge, new row must survive
      issue(C_RD, 2'd1, 12'h400);
      issue(C_PRE, 2'd1, 12'h000);
      chk("R11 pre closes", bank_open, 4'b0000);
      issue(C_ACT, 2'd1, 12'h009);
      idle(2);
      chk("R11 burst over", burst_busy, 0);
      chk("R11 cancelled ap", bank_open, 4'b0010);
      chk("R11 new row", bank_row[23:12], 12'h009);
   endtask

   task automatic t_precharge;
      issue(C_ACT, 2'd0, 12'h111);
      issue(C_ACT, 2'd3, 12'h333);
      chk("R3 three open", bank_open, 4'b1011);
      issue(C_PRE, 2'd3, 12'h000);
      chk("R4 one closed", bank_open, 4'b0011);
      issue(C_PRE, 2'd2, 12'h400);
      chk("R4 all closed", bank_open, 4'b0000);
   endtask

   task automatic t_autoclose;
      issue(C_MRS, 2'd0, 12'h002);
      chk("R8 len 4", burst_len, 4);
      issue(C_ACT, 2'd1, 12'h0AA);
      issue(C_WR, 2'd1, 12'h400);
      idle(1);
      chk("R7 busy last", burst_busy, 1);
      chk("R7 still open", bank_open, 4'b0010);
      issue(C_ACT, 2'd1, 12'h0BB);
      chk("R7 act on close edge err", proto_err, 1);
      chk("R7 closed with burst", bank_open, 4'b0000);
      chk("R6 busy fell", burst_busy, 0);
      issue(C_ACT, 2'd1, 12'h0BB);
      chk("R3 reopen ok", proto_err, 0);
      issue(C_RD, 2'd1, 12'h400);
      issue(C_RD, 2'd1, 12'h000);
      chk("R11 rw during ap err", proto_err, 1);
      idle(1);
      chk("R11 ignored read", burst_busy, 0);
      chk("R7 ap closed", bank_open, 4'b0000);
   endtask

   task automatic t_cke;
      issue(C_ACT, 2'd1, 12'h0CC);
      issue(C_RD, 2'd1, 12'h000);
      idle(1);
      issue(C_NOP, 2'd0, 12'h000, 1'b0, 1'b0);
      chk("R9 cke drop err", proto_err, 1);
      chk("R10 active pd", pd_mode, 2);
      issue(C_ACT, 2'd0, 12'h001, 1'b0, 1'b0);
      chk("R10 ignored act", bank_open, 4'b0010);
      chk("R9 no err outside burst", proto_err, 0);
      idle(1);
      chk("R10 pd cleared", pd_mode, 0);
      issue(C_PRE, 2'd0, 12'h400);
      issue(C_NOP, 2'd0, 12'h000, 1'b0, 1'b0);
      chk("R10 precharge pd", pd_mode, 1);
      chk("R10 no err idle", proto_err, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cs_n = 1'b0;
      @(negedge clk);
      t_reset();
      t_mask();
      t_activate();
      t_closed_rw();
      t_mode();
      t_burst8();
      t_precharge();
      t_autoclose();
      t_cke();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (200000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule